// File: doc/BRIEF.md
# UART Channel Interrupt Pending and Mask Unit

This unit gathers the four interrupt causes of a single UART channel (receive, error, transmit and modem status) into one level interrupt for the parent interrupt controller. Each cause has a sticky flag that a one-cycle event pulse from the UART logic sets. Each cause also has a mask bit. Software reaches the flags and masks through three registers on a small memory-mapped bus. The bus has a write strobe and an address, and read data is returned combinationally for the presented address.

The raw register shows every latched flag, masked or not. The pending register shows only flags whose mask bit is clear. Software acknowledges a cause by writing one to its bit in the pending register. To find the active causes, software reads the pending register and walks its bits from bit 0 upward. To service a cause with mask-then-acknowledge, software first sets the mask bit and then clears the flag. Until the flag is cleared, masking hides it without losing it.

Top module: `uirq_pend_unit`

## Requirements
- R1: The fixed bit order is receive at bit 0, error at bit 1, transmit at bit 2 and modem status at bit 3, for the event inputs and for all three registers.
- R2: A high event input sets its flag at the next clock edge. The raw register at offset 0x34 shows that flag whatever the mask holds.
- R3: A read of the pending register at offset 0x30 returns the flags that are set and whose mask bit is 0. All other bits read as 0.
- R4: A write to offset 0x38 loads the mask from write data bits 3:0, where 1 masks a cause and 0 enables it. A read of 0x38 returns the mask.
- R5: A write to offset 0x30 clears every flag whose write data bit is 1. Flags whose write data bit is 0 are left unchanged.
- R6: When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: The interrupt output is high exactly when at least one flag is set and unmasked. It stays high until those flags are cleared or masked.
- R8: After reset, the mask reads 0xF, all flags are 0 and the interrupt output is low.
- R9: Writes to offset 0x34 or to unmapped offsets change no state. Reads of unmapped offsets return 0.
- R10: Setting a mask bit does not clear its flag. A later write of one to the pending register clears the flag, and the interrupt stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | AW (8) | Register byte offset |
| bus_wdata | input | DW (32) | Write data; only bits 3:0 are used |
| bus_rdata | output | DW (32) | Read data for bus_addr, zero-extended |
| src_evt | input | 4 | Per-cause event pulses: receive, error, transmit, modem |
| irq_out | output | 1 | Combined level interrupt to the parent controller |

## Verification
The assertions assume that the event inputs and bus signals are stable and known at each rising edge. They also assume that an event can be high in the same cycle as any bus write, including a clear of its own flag. The bench drives every input on the falling edge, holds each for exactly one cycle and returns it to zero. Events therefore arrive as clean single-cycle pulses, and a same-cycle event and clear is created on purpose, never by accident. Read checks are taken between edges with no write pending, so the combinational read path is observed on settled state.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NSRC = 4;

  typedef logic [NSRC-1:0] srcvec_t;

  localparam srcvec_t MASK_AT_RESET = '1;

  // next state of one flag: a set beats a clear in the same cycle
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // flags that are allowed to be seen and to raise the interrupt
  function automatic srcvec_t unmasked(srcvec_t raw, srcvec_t msk);
    return raw & ~msk;
  endfunction
endpackage

// File: rtl/uirq_bus_decode.sv
module uirq_bus_decode #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] PEND_OFS = 'h30,
  parameter logic [AW-1:0] RAW_OFS  = 'h34,
  parameter logic [AW-1:0] MASK_OFS = 'h38
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          hit_pend,
  output logic          hit_raw,
  output logic          hit_mask,
  output logic          clr_wr,
  output logic          mask_wr
);
  always_comb begin
    hit_pend = (addr == PEND_OFS);
    hit_raw  = (addr == RAW_OFS);
    hit_mask = (addr == MASK_OFS);
    clr_wr   = wr & hit_pend;
    mask_wr  = wr & hit_mask;
  end
endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank
  import uirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  srcvec_t set_vec,
  input  srcvec_t clr_vec,
  output srcvec_t raw_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= flag_next(raw_q[i], set_vec[i], clr_vec[i]);
    end
  end
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
  import uirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  srcvec_t load_val,
  output srcvec_t mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= MASK_AT_RESET;
    else if (load) mask_q <= load_val;
  end
endmodule

// File: rtl/uirq_irq_combine.sv
module uirq_irq_combine
  import uirq_pkg::*;
(
  input  srcvec_t raw,
  input  srcvec_t msk,
  output srcvec_t vis,
  output logic    irq
);
  always_comb begin
    vis = unmasked(raw, msk);
    irq = |vis;
  end
endmodule

// File: rtl/uirq_pend_unit.sv
module uirq_pend_unit
  import uirq_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] PEND_OFS = 'h30,
  parameter logic [AW-1:0] RAW_OFS  = 'h34,
  parameter logic [AW-1:0] MASK_OFS = 'h38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3:0]    src_evt,
  output logic          irq_out
);
  // named internal events, visible to the bound checker
  srcvec_t wdata_lo;
  srcvec_t clr_vec;
  srcvec_t raw_q;
  srcvec_t mask_q;
  srcvec_t vis;
  logic    hit_pend, hit_raw, hit_mask;
  logic    clr_wr, mask_wr;
  logic    unused_wdata_hi;

  assign wdata_lo        = bus_wdata[NSRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DW-1:NSRC];
  assign clr_vec         = clr_wr ? wdata_lo : '0;

  uirq_bus_decode #(
    .AW(AW), .PEND_OFS(PEND_OFS), .RAW_OFS(RAW_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .wr(bus_wr), .addr(bus_addr),
    .hit_pend(hit_pend), .hit_raw(hit_raw), .hit_mask(hit_mask),
    .clr_wr(clr_wr), .mask_wr(mask_wr)
  );

  uirq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(src_evt), .clr_vec(clr_vec), .raw_q(raw_q)
  );

  uirq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_wr), .load_val(wdata_lo), .mask_q(mask_q)
  );

  uirq_irq_combine u_comb (
    .raw(raw_q), .msk(mask_q), .vis(vis), .irq(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_pend)      bus_rdata[NSRC-1:0] = vis;
    else if (hit_raw)  bus_rdata[NSRC-1:0] = raw_q;
    else if (hit_mask) bus_rdata[NSRC-1:0] = mask_q;
  end
endmodule

// File: rtl/uirq_pend_chk.sv
module uirq_pend_chk
  import uirq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input srcvec_t evt,
  input srcvec_t clr_vec,
  input logic    mask_wr,
  input srcvec_t wdata_lo,
  input srcvec_t raw_q,
  input srcvec_t mask_q,
  input logic    irq
);
  // R2 R6
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~evt) != '0) |=> ((raw_q & $past(clr_vec & ~evt)) == '0));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && clr_vec == '0) |=> $stable(raw_q));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata_lo)));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R7
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr_vec == '0 && !mask_wr) |=> irq);

  // R8
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == MASK_AT_RESET && raw_q == '0));
endmodule

bind uirq_pend_unit uirq_pend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_vec(clr_vec),
  .mask_wr(mask_wr), .wdata_lo(wdata_lo), .raw_q(raw_q),
  .mask_q(mask_q), .irq(irq_out)
);

// File: tb/uirq_pend_unit_test.sv
module uirq_pend_unit_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NV = 16;
  localparam int VW = 30;

  // fields: evt[29:26] wr[25] waddr[24:17] wdata[16:13] raddr[12:5] exp[4:1] irq[0]
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'h1, 1'b0, 8'h00, 4'h0, 8'h34, 4'h1, 1'b0},  // R2 masked rx still latched
    {4'h0, 1'b1, 8'h38, 4'hE, 8'h30, 4'h1, 1'b1},  // R4 unmask rx
    {4'h8, 1'b0, 8'h00, 4'h0, 8'h34, 4'h9, 1'b1},  // R2 modem event
    {4'h0, 1'b1, 8'h38, 4'h0, 8'h30, 4'h9, 1'b1},  // R3 all enabled
    {4'h0, 1'b1, 8'h30, 4'h1, 8'h30, 4'h8, 1'b1},  // R5 clear rx
    {4'h0, 1'b1, 8'h30, 4'h0, 8'h34, 4'h8, 1'b1},  // R5 zero write
    {4'h2, 1'b1, 8'h30, 4'h2, 8'h34, 4'hA, 1'b1},  // R6 event beats clear
    {4'h0, 1'b1, 8'h30, 4'hA, 8'h34, 4'h0, 1'b0},  // R7 all cleared
    {4'h4, 1'b0, 8'h00, 4'h0, 8'h30, 4'h4, 1'b1},  // R1 tx at bit 2
    {4'h0, 1'b1, 8'h34, 4'hF, 8'h34, 4'h4, 1'b1},  // R9 raw write ignored
    {4'h0, 1'b1, 8'h3C, 4'hF, 8'h38, 4'h0, 1'b1},  // R9 unmapped write
    {4'h0, 1'b0, 8'h00, 4'h0, 8'h3C, 4'h0, 1'b1},  // R9 unmapped read
    {4'h0, 1'b1, 8'h38, 4'h4, 8'h34, 4'h4, 1'b0},  // R10 mask keeps flag
    {4'h0, 1'b0, 8'h00, 4'h0, 8'h30, 4'h0, 1'b0},  // R3 masked hidden
    {4'h0, 1'b1, 8'h30, 4'h4, 8'h34, 4'h0, 1'b0},  // R10 ack after mask
    {4'h0, 1'b1, 8'h38, 4'hF, 8'h38, 4'hF, 1'b0}   // R4 mask all
  };

  localparam string VREQ [NV] = '{"R2", "R4", "R2", "R3", "R5", "R5", "R6", "R7",
                                  "R1", "R9", "R9", "R9", "R10", "R3", "R10", "R4"};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [3:0]    src_evt;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uirq_pend_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt), .irq_out(irq_out)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle with optional events, then a settled read of raddr
  task automatic step(logic [3:0] evt, logic wr, logic [AW-1:0] wa, logic [3:0] wd,
                      logic [AW-1:0] ra);
    @(negedge clk);
    src_evt = evt; bus_wr = wr; bus_addr = wa; bus_wdata = DW'(wd);
    @(negedge clk);
    src_evt = '0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = ra;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reset_checks(string tag);
    @(negedge clk);
    bus_addr = 8'h38; #1; check({tag, " R8 mask"}, bus_rdata, 32'hF);
    bus_addr = 8'h34; #1; check({tag, " R8 raw"}, bus_rdata, 32'h0);
    bus_addr = 8'h30; #1; check({tag, " R8 pend"}, bus_rdata, 32'h0);
    check({tag, " R8 irq"}, {31'b0, irq_out}, 32'h0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_evt = '0;
    do_reset();
    reset_checks("initial");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[29:26], v[25], v[24:17], v[16:13], v[12:5]);
      check($sformatf("%s vec%0d rdata", VREQ[i], i), bus_rdata, DW'(v[4:1]));
      check($sformatf("%s vec%0d irq", VREQ[i], i), {31'b0, irq_out}, {31'b0, v[0]});
    end

    // R1 each cause lands on its own bit, seen through the pending register
    step(4'h0, 1'b1, 8'h38, 4'h0, 8'h30);
    for (int b = 0; b < 4; b++) begin
      step(4'(1 << b), 1'b0, 8'h00, 4'h0, 8'h30);
      check($sformatf("R1 bit%0d pend", b), bus_rdata, DW'(1 << b));
      check($sformatf("R7 bit%0d irq", b), {31'b0, irq_out}, 32'h1);
      step(4'h0, 1'b1, 8'h30, 4'(1 << b), 8'h34);
      check($sformatf("R5 bit%0d cleared", b), bus_rdata, 32'h0);
    end

    // R2 all four at once; R7 stays high over idle cycles
    step(4'hF, 1'b0, 8'h00, 4'h0, 8'h30);
    check("R2 all four", bus_rdata, 32'hF);
    repeat (5) @(negedge clk);
    #1;
    check("R7 held high", {31'b0, irq_out}, 32'h1);
    // R6 clear three while a receive event lands
    step(4'h1, 1'b1, 8'h30, 4'hF, 8'h34);
    check("R6 rx survives clear", bus_rdata, 32'h1);

    // R8 reset while busy
    step(4'hE, 1'b1, 8'h38, 4'h0, 8'h34);
    do_reset();
    reset_checks("midrun");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule